// File: doc/BRIEF.md
# Fan Start and Stall Recovery Supervisor

This block supervises a brushless fan motor at start-up and after a stall. It accepts a run command, a one-cycle strobe for each Hall sensor transition, and three status flags: over-temperature, low supply and sleep. From these it produces a global drive enable, a force-full-duty kick request for the speed modulator, a fault flag, and a tachometer line.

Every fresh start forces full drive for a fixed kick interval. A fresh start is a run command from rest, or a return from sleep, over-temperature, low supply or a cleared stall. After the kick, the block watches for Hall transitions. If the drive stays on for one lock window with no transition, the rotor is declared stalled. The drives then alternate between a long cool-down with the drive off and a short retry with the drive on, until rotation is seen again.

All intervals are counted by one shared timebase in clock cycles. The interval lengths are parameters, so a bench can shorten them.

Top module: `fan_start_supervisor`

## Requirements
- R1: After reset, drive_en, kick_full, fault_flag and tach_out are all 0.
- R2: When run_cmd is 1 and no inhibit flag is set, the block starts from rest. kick_full and drive_en are then both 1 for exactly KICK_TICKS consecutive cycles. After that, drive_en stays 1 and kick_full is 0.
- R3: After the kick, drive_en stays 1 as long as the gap between Hall strobes is shorter than ON_TICKS cycles. If ON_TICKS cycles pass with no strobe, counted from the last strobe or from the end of the kick, drive_en goes to 0 and fault_flag goes to 1.
- R4: After a stall, drive_en is 0 for OFF_TICKS cycles and then 1 for ON_TICKS cycles. This cycle repeats and fault_flag stays 1 throughout.
- R5: A Hall strobe during a retry interval clears fault_flag and starts a new kick of KICK_TICKS cycles. This also holds for a strobe in the last cycle of the retry interval: the strobe takes priority over the expiry of the interval.
- R6: While therm_trip or supply_low is 1, drive_en and kick_full are 0 in that same cycle, and no fault is raised. This holds even in the cycle where a stall would otherwise be declared. When both flags clear, a kick of KICK_TICKS cycles follows.
- R7: While sleep_mode is 1, drive_en is 0 from the next cycle on. When sleep_mode clears, a kick of KICK_TICKS cycles follows.
- R8: When run_cmd is 0, drive_en, kick_full and fault_flag are 0 from the next cycle on, whatever the state was. While run_cmd is 0, Hall strobes do not enable the drive.
- R9: Each Hall strobe toggles an internal speed level one cycle later. tach_out shows this level while fault_flag is 0 and is 1 while fault_flag is 1.
- R10: Hall strobes during a kick or during a cool-down change neither the length of that interval nor fault_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_cmd | input | 1 | Fan commanded to run |
| hall_edge | input | 1 | One-cycle strobe per Hall transition |
| therm_trip | input | 1 | Over-temperature shutdown active |
| supply_low | input | 1 | Supply undervoltage lockout active |
| sleep_mode | input | 1 | Low-power sleep requested |
| drive_en | output | 1 | Global motor drive enable |
| kick_full | output | 1 | Force full duty (kick start) |
| fault_flag | output | 1 | Stalled-rotor fault pending |
| tach_out | output | 1 | Tachometer line, held high on fault |

## Verification
Two functions can fall in the same cycle: a Hall strobe and the expiry of the retry window. The bench provokes this by counting the drive-on samples of a retry and placing the strobe exactly on the last one. It then expects a kick and a cleared fault rather than another cool-down. A second collision is an over-temperature flag raised in the last cycle of the lock window. Here the bench expects the drive to be cut in that same cycle and no fault to be raised.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_KICK     = 3'd1,
    ST_RUN      = 3'd2,
    ST_RETRY_ON = 3'd3,
    ST_COOL_OFF = 3'd4,
    ST_INHIBIT  = 3'd5
  } fsup_state_e;

  // States in which the motor phases may conduct.
  function automatic logic drives_on(input fsup_state_e s);
    return (s == ST_KICK) || (s == ST_RUN) || (s == ST_RETRY_ON);
  endfunction

  // An interval of len cycles ends in the cycle whose count is len-1.
  function automatic logic interval_done(input logic [31:0] cnt, input int unsigned len);
    return cnt == 32'(len - 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fsup_timebase.sv
module fsup_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fsup_fsm.sv
module fsup_fsm
  import fsup_pkg::*;
#(
  parameter int unsigned ON_TICKS   = 8,
  parameter int unsigned OFF_TICKS  = 20,
  parameter int unsigned KICK_TICKS = 12,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_cmd,
  input  logic             hall_edge,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] cnt,
  output fsup_state_e      state,
  output logic             restart,
  output logic             fault_flag,
  output logic             lock_event,
  output logic             rotation_event,
  output logic             start_event
);

  fsup_state_e nxt;
  logic        kick_done, win_done, cool_done, spin_seen;

  assign kick_done = interval_done(32'(cnt), KICK_TICKS);
  assign win_done  = interval_done(32'(cnt), ON_TICKS);
  assign cool_done = interval_done(32'(cnt), OFF_TICKS);

  always_comb begin
    nxt            = state;
    lock_event     = 1'b0;
    rotation_event = 1'b0;
    if (!run_cmd) begin
      nxt = ST_IDLE;
    end else if (inhibit) begin
      nxt = ST_INHIBIT;
    end else begin
      unique case (state)
        ST_IDLE, ST_INHIBIT: nxt = ST_KICK;
        ST_KICK:     if (kick_done) nxt = ST_RUN;
        ST_RUN: begin
          if (!hall_edge && win_done) begin
            nxt        = ST_COOL_OFF;
            lock_event = 1'b1;
          end
        end
        ST_COOL_OFF: if (cool_done) nxt = ST_RETRY_ON;
        ST_RETRY_ON: begin
          if (hall_edge) begin
            nxt            = ST_KICK;
            rotation_event = 1'b1;
          end else if (win_done) begin
            nxt = ST_COOL_OFF;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign restart     = (nxt != state) || ((state == ST_RUN) && hall_edge);
  assign start_event = (nxt == ST_KICK) && (state != ST_KICK);
  assign spin_seen   = hall_edge && run_cmd && !inhibit && drives_on(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fault_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (!run_cmd)        fault_flag <= 1'b0;
      else if (lock_event) fault_flag <= 1'b1;
      else if (spin_seen)  fault_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/fsup_tach.sv
module fsup_tach (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_edge,
  input  logic fault_flag,
  output logic tach_out
);

  logic speed_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         speed_lvl <= 1'b0;
    else if (hall_edge) speed_lvl <= ~speed_lvl;
  end

  assign tach_out = speed_lvl | fault_flag;

endmodule

// File: rtl/fan_start_supervisor.sv
module fan_start_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned ON_TICKS   = 12_500_000,
  parameter int unsigned OFF_TICKS  = 100_000_000,
  parameter int unsigned KICK_TICKS = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_cmd,
  input  logic hall_edge,
  input  logic therm_trip,
  input  logic supply_low,
  input  logic sleep_mode,
  output logic drive_en,
  output logic kick_full,
  output logic fault_flag,
  output logic tach_out
);

  localparam int unsigned CNT_W = width_for(max3(ON_TICKS, OFF_TICKS, KICK_TICKS));

  fsup_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             restart, inhibit, hard_cut;
  logic             lock_event, rotation_event, start_event;

  assign inhibit  = therm_trip | supply_low | sleep_mode;
  assign hard_cut = therm_trip | supply_low;

  fsup_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .cnt     (cnt)
  );

  fsup_fsm #(
    .ON_TICKS   (ON_TICKS),
    .OFF_TICKS  (OFF_TICKS),
    .KICK_TICKS (KICK_TICKS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_cmd        (run_cmd),
    .hall_edge      (hall_edge),
    .inhibit        (inhibit),
    .cnt            (cnt),
    .state          (state),
    .restart        (restart),
    .fault_flag     (fault_flag),
    .lock_event     (lock_event),
    .rotation_event (rotation_event),
    .start_event    (start_event)
  );

  fsup_tach u_tach (
    .clk        (clk),
    .rst_n      (rst_n),
    .hall_edge  (hall_edge),
    .fault_flag (fault_flag),
    .tach_out   (tach_out)
  );

  assign drive_en  = drives_on(state) & ~hard_cut;
  assign kick_full = (state == ST_KICK) & ~hard_cut;

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int unsigned KICK_TICKS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic run_cmd,
  input logic therm_trip,
  input logic supply_low,
  input logic sleep_mode,
  input logic drive_en,
  input logic kick_full,
  input logic fault_flag,
  input logic tach_out,
  input logic lock_event
);

  int unsigned kick_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      kick_len <= 0;
    else if (!kick_full)             kick_len <= 0;
    else if (kick_len < KICK_TICKS)  kick_len <= kick_len + 1;
  end

  assert_kick_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_full |-> (kick_len < KICK_TICKS));

  assert_lock_raises_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_event |=> (fault_flag && !drive_en));

  assert_fault_rise_drive_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !drive_en);

  assert_hard_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_trip || supply_low) |-> (!drive_en && !kick_full));

  assert_sleep_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode && run_cmd) |=> !drive_en);

  assert_run_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_cmd |=> (!drive_en && !kick_full && !fault_flag));

  assert_tach_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> tach_out);

endmodule

bind fan_start_supervisor fsup_checker #(.KICK_TICKS(KICK_TICKS)) u_fsup_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_cmd    (run_cmd),
  .therm_trip (therm_trip),
  .supply_low (supply_low),
  .sleep_mode (sleep_mode),
  .drive_en   (drive_en),
  .kick_full  (kick_full),
  .fault_flag (fault_flag),
  .tach_out   (tach_out),
  .lock_event (lock_event)
);

// File: tb/test_fan_start_supervisor.sv
`timescale 1ns/1ps
module test_fan_start_supervisor;

  localparam int ON_T   = 8;
  localparam int OFF_T  = 20;
  localparam int KICK_T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_cmd = 1'b0, hall_edge = 1'b0;
  logic therm_trip = 1'b0, supply_low = 1'b0, sleep_mode = 1'b0;
  logic drive_en, kick_full, fault_flag, tach_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit par = 1'b0;

  always #10 clk = ~clk;

  fan_start_supervisor #(.ON_TICKS(ON_T), .OFF_TICKS(OFF_T), .KICK_TICKS(KICK_T)) i_fan_start_supervisor (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .hall_edge(hall_edge),
    .therm_trip(therm_trip), .supply_low(supply_low), .sleep_mode(sleep_mode),
    .drive_en(drive_en), .kick_full(kick_full), .fault_flag(fault_flag), .tach_out(tach_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse();
    hall_edge = 1'b1;
    cyc();
    hall_edge = 1'b0;
    par = ~par;
  endtask

  task automatic count_kick(output int n);
    n = 0;
    while (kick_full && n < 1000) begin n++; cyc(); end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (drive_en && n < 1000) begin n++; cyc(); end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!drive_en && n < 1000) begin n++; cyc(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) cyc();
    chk("R1 drive_en", drive_en, 0);
    chk("R1 kick_full", kick_full, 0);
    chk("R1 fault_flag", fault_flag, 0);
    chk("R1 tach_out", tach_out, 0);
    rst_n = 1'b1;
    cyc();

    // R2 start from rest
    run_cmd = 1'b1;
    cyc();
    chk("R2 drive during kick", drive_en, 1);
    count_kick(n);
    chk("R2 kick length", n, KICK_T);
    chk("R2 drive after kick", drive_en, 1);

    // R3 running with regular Hall strobes
    for (int i = 0; i < 6; i++) begin
      repeat (4) cyc();
      pulse();
    end
    chk("R3 drive with strobes", drive_en, 1);
    chk("R3 no fault", fault_flag, 0);
    chk("R9 tach level", tach_out, int'(par));

    // R3 lock window then R4 cadence
    count_high(n);
    chk("R3 lock window", n, ON_T);
    chk("R3 fault set", fault_flag, 1);
    chk("R9 tach forced", tach_out, 1);
    count_low(n);
    chk("R4 cool length", n, OFF_T);
    count_high(n);
    chk("R4 retry length", n, ON_T);
    chk("R4 fault held", fault_flag, 1);

    // R10 strobe in cool-down ignored
    n = 0;
    while (!drive_en && n < 1000) begin
      hall_edge = (n == 5);
      n++;
      cyc();
    end
    hall_edge = 1'b0;
    par = ~par;
    chk("R10 cool length with strobe", n, OFF_T);
    chk("R10 fault after cool strobe", fault_flag, 1);

    // R5 strobe on the last retry cycle wins
    repeat (ON_T - 1) cyc();
    chk("R5 still retrying", drive_en, 1);
    pulse();
    chk("R5 kick after rotation", kick_full, 1);
    chk("R5 fault cleared", fault_flag, 0);
    chk("R9 tach follows level", tach_out, int'(par));

    // R10 strobe during kick ignored
    n = 0;
    while (kick_full && n < 1000) begin
      hall_edge = (n == 3);
      n++;
      cyc();
    end
    hall_edge = 1'b0;
    par = ~par;
    chk("R10 kick length with strobe", n, KICK_T);

    // R6 over-temperature
    therm_trip = 1'b1;
    #1;
    chk("R6 therm cuts drive", drive_en, 0);
    chk("R6 therm cuts kick", kick_full, 0);
    repeat (3) cyc();
    chk("R6 therm held off", drive_en, 0);
    chk("R6 therm no fault", fault_flag, 0);
    therm_trip = 1'b0;
    cyc();
    count_kick(n);
    chk("R6 kick after therm", n, KICK_T);

    // R6 low supply
    supply_low = 1'b1;
    #1;
    chk("R6 supply cuts drive", drive_en, 0);
    repeat (2) cyc();
    supply_low = 1'b0;
    cyc();
    count_kick(n);
    chk("R6 kick after supply", n, KICK_T);

    // R7 sleep
    sleep_mode = 1'b1;
    #1;
    chk("R7 sleep not immediate", drive_en, 1);
    cyc();
    chk("R7 sleep drive off", drive_en, 0);
    repeat (3) cyc();
    chk("R7 sleep held off", drive_en, 0);
    sleep_mode = 1'b0;
    cyc();
    count_kick(n);
    chk("R7 kick after sleep", n, KICK_T);

    // R8 run drop during cool-down
    count_high(n);
    chk("R3 lock after kick", n, ON_T);
    repeat (4) cyc();
    chk("R8 fault before drop", fault_flag, 1);
    run_cmd = 1'b0;
    cyc();
    chk("R8 fault cleared", fault_flag, 0);
    chk("R8 drive off", drive_en, 0);
    chk("R9 tach after drop", tach_out, int'(par));
    pulse();
    chk("R8 strobe idle drive", drive_en, 0);
    chk("R9 idle strobe toggles", tach_out, int'(par));
    repeat (30) cyc();
    chk("R8 idle stays off", drive_en, 0);

    // R8 run drop during kick
    run_cmd = 1'b1;
    repeat (2) cyc();
    chk("R2 kick restarted", kick_full, 1);
    run_cmd = 1'b0;
    cyc();
    chk("R8 kick dropped", kick_full, 0);
    chk("R8 drive dropped", drive_en, 0);

    // R6 inhibit in the last cycle of the lock window
    run_cmd = 1'b1;
    cyc();
    count_kick(n);
    chk("R2 kick again", n, KICK_T);
    repeat (ON_T - 1) cyc();
    chk("R3 last window cycle", drive_en, 1);
    therm_trip = 1'b1;
    #1;
    chk("R6 collision drive", drive_en, 0);
    cyc();
    chk("R6 collision no fault", fault_flag, 0);
    therm_trip = 1'b0;
    cyc();
    chk("R6 collision kick", kick_full, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule